// File: doc/BRIEF.md
# DAC Dither Sub-Conversion Sequencer

This block sits between a sample source and a 12-bit DAC core. It accepts 16-bit unsigned samples through a valid/ready handshake. In dithered mode the top twelve bits form a base code and the low four bits form a fraction. The sample is then converted as sixteen sub-conversions. Each one drives either the base code or the base code plus one. Exactly as many slots get the extra step as the fraction counts, so the mean of the sixteen codes reproduces the full 16-bit value.

A 4-bit accumulator spreads the raised slots evenly across the run instead of grouping them. Each code is presented with a one-cycle strobe. The next strobe waits out a fixed conversion time, 24 clocks by default. With dither off, the sample is a plain 12-bit code taken from the high or low end of the word, and it is converted once.

Top module: `dac_dither_sequencer`

## Requirements
- R1: A synchronous reset drives `dac_code` to 0, `dac_strobe` low, `busy` low and `in_ready` high, and abandons any sequence in flight.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is the inverse of `busy`.
- R3: In dithered mode (`dither_en` = 1) the base code is bits [15:4] and the fraction N is bits [3:0], whatever the value of `left_adj`.
- R4: A dithered sample produces exactly 16 strobes. When the base code is below 0xFFF, exactly N of them carry base+1 and the rest carry the base code.
- R5: Slot k (0 to 15) of a dithered run carries base+1 exactly when floor((k+1)·N/16) exceeds floor(k·N/16). The raised slots are therefore spread across the run, not bunched together.
- R6: When the base code is 0xFFF, every slot outputs 0xFFF, so the code never wraps to zero.
- R7: The first strobe is high in the cycle after the accepting edge. Successive strobes are exactly CONV_CYCLES (24) cycles apart. `busy` stays high from the accepting edge until CONV_CYCLES cycles after the last strobe.
- R8: In plain mode (`dither_en` = 0) a single strobe is issued. Its code is bits [15:4] when `left_adj` = 1 and bits [11:0] when `left_adj` = 0.
- R9: Changes on `in_valid`, `in_sample`, `dither_en` and `left_adj` while `busy` is high have no effect on the codes of the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle, able to take a sample |
| in_sample | input | 16 | Unsigned sample word |
| dither_en | input | 1 | 1: sixteen dithered sub-conversions; 0: one plain conversion |
| left_adj | input | 1 | Plain mode only: 1 takes the code from the high bits, 0 from the low bits |
| busy | output | 1 | Sequence in progress |
| dac_code | output | 12 | Code to the DAC core, held between strobes |
| dac_strobe | output | 1 | One-cycle pulse starting a sub-conversion |

## Verification
The first strobe and its code are due one cycle after the accepting edge. Each later strobe is due 24·k cycles after that edge. The fall of `busy` is due 24 cycles after the last strobe, which is 384 cycles for a dithered run and 24 for a plain one. The bench counts cycles from the accepting edge and samples every output at the falling edge of each cycle in that window. It checks the strobe and the `busy` level on every cycle, and the code on the cycles where a strobe is due. During the run it drives random values onto all the inputs, so any leak into the codes or any early acceptance shows up as a code or timing mismatch.

// File: rtl/dds_pkg.sv
package dds_pkg;
  parameter int CODE_W   = 12;
  parameter int FRAC_W   = 4;
  parameter int SAMPLE_W = CODE_W + FRAC_W;
  parameter int SUBS     = 1 << FRAC_W;

  typedef logic [CODE_W-1:0]   code_t;
  typedef logic [SAMPLE_W-1:0] sample_t;

  // Code field taken from a sample: dithered words always use the high bits.
  function automatic code_t field_code(sample_t s, logic dith, logic ladj);
    if (dith || ladj) return s[SAMPLE_W-1:FRAC_W];
    return s[CODE_W-1:0];
  endfunction

  // Add one to a code, pinned at full scale.
  function automatic code_t sat_inc(code_t c, logic inc);
    if (inc && (c != '1)) return c + code_t'(1);
    return c;
  endfunction
endpackage

// File: rtl/dds_conv_timer.sv
module dds_conv_timer #(
  parameter int CONV_CYCLES = 24,
  parameter int TW          = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic [TW-1:0] count,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= TW'(CONV_CYCLES - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign count = cnt_q;
  assign done  = (cnt_q == '0);

  // R7: a load always starts a full window
  a_r7_load_full: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == TW'(CONV_CYCLES - 1)));
endmodule

// File: rtl/dds_slot_spreader.sv
module dds_slot_spreader import dds_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FRAC_W-1:0] start_frac,
  input  logic              step,
  output logic [FRAC_W-1:0] slot,
  output logic              plus_one
);
  logic [FRAC_W-1:0] frac_q, acc_q, slot_q;
  logic [FRAC_W:0]   sum;

  assign sum      = {1'b0, acc_q} + {1'b0, frac_q};
  assign plus_one = sum[FRAC_W];
  assign slot     = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= '0;
      acc_q  <= '0;
      slot_q <= '0;
    end else if (start) begin
      // slot 0: accumulator moves from 0 to N, never a carry
      frac_q <= start_frac;
      acc_q  <= start_frac;
      slot_q <= '0;
    end else if (step) begin
      acc_q  <= sum[FRAC_W-1:0];
      slot_q <= slot_q + FRAC_W'(1);
    end
  end

  // R4: after sixteen additions of N the accumulator is back at zero
  a_r4_acc_wraps: assert property (@(posedge clk) disable iff (rst)
    (slot == FRAC_W'(SUBS - 1)) |-> (acc_q == '0));
  // R5: the first slot of a run is never raised
  a_r5_first_slot_base: assert property (@(posedge clk) disable iff (rst)
    start |=> (slot == '0));
endmodule

// File: rtl/dac_dither_sequencer.sv
module dac_dither_sequencer import dds_pkg::*; #(
  parameter int CONV_CYCLES = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                dither_en,
  input  logic                left_adj,
  output logic                busy,
  output logic [CODE_W-1:0]   dac_code,
  output logic                dac_strobe
);
  localparam int TW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;

  // named events
  logic accept, step, finish, tmr_done, plus_one, last_slot;
  logic [TW-1:0]     tmr_cnt;
  logic [FRAC_W-1:0] slot;

  logic  busy_q, dith_q, strobe_q;
  code_t base_q, code_q;

  assign in_ready  = !busy_q;
  assign accept    = in_valid && !busy_q;
  assign last_slot = dith_q ? (slot == FRAC_W'(SUBS - 1)) : 1'b1;
  assign step      = busy_q && tmr_done && !last_slot;
  assign finish    = busy_q && tmr_done && last_slot;

  dds_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .TW(TW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .load  (accept || step),
    .count (tmr_cnt),
    .done  (tmr_done)
  );

  dds_slot_spreader u_spr (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_frac (in_sample[FRAC_W-1:0]),
    .step       (step),
    .slot       (slot),
    .plus_one   (plus_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      dith_q   <= 1'b0;
      base_q   <= '0;
      code_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        dith_q   <= dither_en;
        base_q   <= field_code(in_sample, dither_en, left_adj);
        code_q   <= field_code(in_sample, dither_en, left_adj);
        strobe_q <= 1'b1;
      end else if (step) begin
        code_q   <= sat_inc(base_q, plus_one);
        strobe_q <= 1'b1;
      end else if (finish) begin
        busy_q   <= 1'b0;
      end
    end
  end

  assign busy       = busy_q;
  assign dac_code   = code_q;
  assign dac_strobe = strobe_q;

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !busy && !dac_strobe));
  // R7: a strobe coincides with a freshly loaded timer
  a_r7_strobe_window: assert property (@(posedge clk) disable iff (rst)
    dac_strobe |-> (tmr_cnt == TW'(CONV_CYCLES - 1)));
  // R7: no strobe inside a run before the timer expired
  a_r7_no_early: assert property (@(posedge clk) disable iff (rst)
    (dac_strobe && $past(busy_q)) |-> $past(tmr_done));
  // R4: a dithered code is the base or one above it
  a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
    (dac_strobe && dith_q) |->
      (dac_code == base_q || {1'b0, dac_code} == {1'b0, base_q} + 13'd1));
  // R6: full scale never wraps
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (dac_strobe && base_q == '1) |-> (dac_code == '1));
  // R8: plain mode has only the first slot
  a_r8_single_slot: assert property (@(posedge clk) disable iff (rst)
    (dac_strobe && !dith_q) |-> (slot == '0));
  // R9: latched sample is frozen while busy
  a_r9_hold_sample: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(base_q) && $stable(dith_q)));
endmodule

// File: tb/dac_dither_sequencer_tb.sv
module dac_dither_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 24;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic        dither_en = 1'b0;
  logic        left_adj = 1'b0;
  logic        busy;
  logic [11:0] dac_code;
  logic        dac_strobe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dither_sequencer #(.CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .dither_en(dither_en), .left_adj(left_adj),
    .busy(busy), .dac_code(dac_code), .dac_strobe(dac_strobe));

  function automatic int exp_code(int s, bit d, bit la, int k);
    int base, n, inc;
    if (!d) return la ? ((s >> 4) & 4095) : (s & 4095);
    base = (s >> 4) & 4095;
    n    = s & 15;
    inc  = ((k + 1) * n) / 16 - (k * n) / 16;
    return (base + inc > 4095) ? 4095 : base + inc;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_reset();
    @(negedge clk);
    check(dac_code == 0 && !dac_strobe && !busy && in_ready,
          "R1 reset state", {dac_code, dac_strobe, busy, in_ready}, 1);
  endtask

  task automatic run(int s, bit d, bit la);
    int subs = d ? 16 : 1;
    int plus = 0;
    int strobes = 0;
    int base = (s >> 4) & 4095;
    bit timing_ok = 1;
    string req;
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready while idle", in_ready, 1);
    in_sample = s[15:0];
    dither_en = d;
    left_adj  = la;
    in_valid  = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= CONV * subs; j++) begin
      bit exp_str;
      @(negedge clk);
      exp_str = (j % CONV == 0) && (j / CONV < subs);
      if (dac_strobe !== exp_str) timing_ok = 0;
      if (busy !== (j < CONV * subs)) timing_ok = 0;
      if (in_ready !== !(j < CONV * subs)) timing_ok = 0;
      if (exp_str) begin
        int e;
        e = exp_code(s, d, la, j / CONV);
        if (!d)                req = "R8 R9 plain code";
        else if (base == 4095) req = "R6 R9 saturated code";
        else                   req = "R3 R5 R9 dither slot code";
        check(int'(dac_code) == e, req, dac_code, e);
        strobes++;
        if (d && int'(dac_code) != base) plus++;
      end
      if (j < CONV * subs - 2) begin
        in_valid  = 1'($urandom % 2);
        in_sample = 16'($urandom);
        dither_en = 1'($urandom % 2);
        left_adj  = 1'($urandom % 2);
      end else begin
        in_valid = 1'b0;
      end
    end
    check(timing_ok, "R7 R2 strobe spacing and busy window", timing_ok, 1);
    check(strobes == subs, "R4 strobe count", strobes, subs);
    if (d && base != 4095) check(plus == (s & 15), "R4 raised slot total", plus, s & 15);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", WATCHDOG, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check_reset();

    // directed corners
    run(16'h1230, 1, 1);   // N = 0: all base
    run(16'h123F, 1, 1);   // N = 15
    run(16'h4568, 1, 0);   // R3: left_adj ignored when dithered
    run(16'hFFF7, 1, 1);   // R6: full scale
    run(16'hFFFF, 1, 0);   // R6
    run(16'h0001, 1, 1);   // single raised slot
    run(16'hABCD, 0, 1);   // R8 high bits
    run(16'hABCD, 0, 0);   // R8 low bits

    for (int i = 0; i < 20; i++) begin
      int s;
      s = int'($urandom & 32'hFFFF);
      run(s, 1'($urandom % 2), 1'($urandom % 2));
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    in_sample = 16'h7777; dither_en = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(dac_code == 0 && !busy && in_ready, "R1 reset mid-run",
          {dac_code, busy, in_ready}, 1);
    run(16'h2225, 1, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule